// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block keeps the control-flow state of one wavefront of SIMD lanes. Its state is a stack of entries. Each entry has a program counter, a reconvergence program counter (the address where the entry's lanes meet their siblings again) and a mask of active lanes. The current pc, the reconvergence pc and the active mask on the outputs always come from the top entry. When the stack is empty the outputs read zero and `stackEmpty` is high.

The front end sends one command per accepted cycle, with a valid/ready handshake. A step moves the top entry to the next sequential address. A jump moves it to a target address. A conditional branch arrives with a per-lane condition vector, a taken target, a fall-through address and the immediate post-dominator. It rebuilds the top of the stack in one cycle. The old top is removed. Then up to three entries are pushed: a continuation entry at the post-dominator, the not-taken path, and the taken path. The taken path is pushed last, so it runs first. A step or jump that lands on the top entry's reconvergence pc removes that entry instead of moving it, which hands control back to the entry below.

Top module: `simt_recon_stack`

## Requirements
- R1: After reset the stack holds one entry: pc = `startPc`, reconvergence pc all ones, mask all ones. `stackEmpty` is 0, all error flags are 0 and `cmdReady` is 1.
- R2: A step (`cmdOp` = 1) on a non-empty stack whose `nextPc` differs from the top reconvergence pc sets the top pc to `nextPc` one cycle later. The reconvergence pc and the mask stay unchanged.
- R3: A step whose `nextPc` equals the top reconvergence pc removes the top entry. When the last entry is removed, `stackEmpty` goes to 1 and the pc, reconvergence pc and mask outputs read zero.
- R4: A jump (`cmdOp` = 2) sets the top pc to `targetPc` and keeps the reconvergence pc and mask. If `targetPc` equals the top reconvergence pc, the jump removes the top entry instead.
- R5: A conditional branch (`cmdOp` = 3) removes the top entry (saved pc S, saved reconvergence pc Q, saved mask M). The taken mask is T = `condMask` & M. It then pushes, in this order:
  - {post-dominator, Q, M} if Q differs from the post-dominator;
  - {`nextPc`, post-dominator, M & ~T} if `nextPc` differs from the post-dominator and popcount(T) < popcount(M);
  - {`targetPc`, post-dominator, T} if `targetPc` differs from the post-dominator and T is non-zero.
- R6: Uniform branches create no empty path. If every active lane is taken, no not-taken entry is pushed. If no lane is taken, no taken entry is pushed, and the top is the not-taken path, or the continuation entry when the fall-through is the post-dominator.
- R7: In the cycle after a conditional branch is accepted, `cmdReady` is 0 for exactly one cycle. A command offered in that cycle is ignored.
- R8: A conditional branch whose `targetPc` equals `nextPc` leaves the stack unchanged and sets the sticky flag `errBadTarget`.
- R9: A conditional branch whose pushes would leave more than DEPTH entries leaves the stack unchanged and sets the sticky flag `errOverflow`.
- R10: Any command accepted while the stack is empty leaves it empty and sets the sticky flag `errUnderflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPc | input | PCW | Pc loaded into the initial entry at reset |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 2 | 0 none, 1 step, 2 jump, 3 conditional branch |
| cmdReady | output | 1 | Command can be accepted this cycle |
| nextPc | input | PCW | Next sequential pc (step target and branch fall-through) |
| targetPc | input | PCW | Jump or branch taken target |
| ipdomPc | input | PCW | Immediate post-dominator of the branch |
| condMask | input | LANES | Per-lane branch condition |
| curPc | output | PCW | Top entry pc |
| curRpc | output | PCW | Top entry reconvergence pc |
| curMask | output | LANES | Top entry active mask |
| stackEmpty | output | 1 | No entries remain |
| errOverflow | output | 1 | Sticky: a push would exceed the depth |
| errUnderflow | output | 1 | Sticky: a command was given to an empty stack |
| errBadTarget | output | 1 | Sticky: branch target equal to the fall-through |

## Verification
Every 4-lane condition vector is applied to a conditional branch from the reset entry in three address layouts. In the first, all three branch addresses differ. In the second, the fall-through is the post-dominator. In the third, the saved reconvergence pc is the post-dominator. Together the layouts separate the three push rules and show whether each is wrongly merged or skipped. After the first layout, the stack is drained entry by entry through reconvergence jumps, which checks the push order and every stored field. Nested branches test the depth limit just under and just over capacity. Separate tests cover the error flags, the busy cycle and steps through to an empty stack.

// File: rtl/simt_pkg.sv
package simt_pkg;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STEP   = 2'd1,
    CMD_JUMP   = 2'd2,
    CMD_BRANCH = 2'd3
  } rs_cmd_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic setPc;      // overwrite top pc
    logic selTarget;  // 1: targetPc, 0: nextPc
    logic pop;        // drop top entry
    logic rebuild;    // conditional-branch rebuild of the top
    logic pushRecon;  // push continuation entry at post-dominator
    logic pushNot;    // push not-taken path
    logic pushTaken;  // push taken path
  } rs_strobe_t;

endpackage

// File: rtl/rs_popcount.sv
module rs_popcount #(
  parameter int W  = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import simt_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 8,
  parameter int PCW   = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [PCW-1:0]   nextPc,
  input  logic [PCW-1:0]   targetPc,
  input  logic [PCW-1:0]   ipdomPc,
  input  logic [LANES-1:0] condMask,
  input  logic [CW-1:0]    depth,
  input  logic [PCW-1:0]   topRpc,
  input  logic [LANES-1:0] topMask,
  output rs_strobe_t       stb,
  output logic             cmdReady,
  output logic             errOverflow,
  output logic             errUnderflow,
  output logic             errBadTarget
);
  logic busyQ;
  logic accept;
  logic isEmpty;
  logic [LANES-1:0] takenMask;
  logic [PW-1:0] cntTaken, cntTop;
  logic wantRecon, wantNot, wantTaken;
  logic [CW+1:0] depthAfter;
  logic overflowHit;
  logic setOvf, setUnd, setBad, startBusy;

  assign cmdReady  = !busyQ;
  assign accept    = cmdValid && cmdReady;
  assign isEmpty   = (depth == '0);
  assign takenMask = condMask & topMask;

  rs_popcount #(.W(LANES)) uPopTaken (.vec(takenMask), .cnt(cntTaken));
  rs_popcount #(.W(LANES)) uPopTop   (.vec(topMask),   .cnt(cntTop));

  assign wantRecon = (topRpc != ipdomPc);
  assign wantNot   = (nextPc != ipdomPc) && (cntTaken < cntTop);
  assign wantTaken = (targetPc != ipdomPc) && (cntTaken != '0);

  assign depthAfter = (CW+2)'(depth) - (CW+2)'(1) + (CW+2)'(wantRecon)
                    + (CW+2)'(wantNot) + (CW+2)'(wantTaken);
  assign overflowHit = depthAfter > (CW+2)'(DEPTH);

  always_comb begin
    stb       = '0;
    setOvf    = 1'b0;
    setUnd    = 1'b0;
    setBad    = 1'b0;
    startBusy = 1'b0;
    if (accept) begin
      unique case (rs_cmd_e'(cmdOp))
        CMD_STEP: begin
          if (isEmpty)                setUnd = 1'b1;
          else if (nextPc == topRpc)  stb.pop = 1'b1;
          else                        stb.setPc = 1'b1;
        end
        CMD_JUMP: begin
          if (isEmpty)                  setUnd = 1'b1;
          else if (targetPc == topRpc)  stb.pop = 1'b1;
          else begin
            stb.setPc     = 1'b1;
            stb.selTarget = 1'b1;
          end
        end
        CMD_BRANCH: begin
          startBusy = 1'b1;
          if (isEmpty)                 setUnd = 1'b1;
          else if (targetPc == nextPc) setBad = 1'b1;
          else if (overflowHit)        setOvf = 1'b1;
          else begin
            stb.rebuild   = 1'b1;
            stb.pushRecon = wantRecon;
            stb.pushNot   = wantNot;
            stb.pushTaken = wantTaken;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ        <= 1'b0;
      errOverflow  <= 1'b0;
      errUnderflow <= 1'b0;
      errBadTarget <= 1'b0;
    end else begin
      busyQ <= startBusy;
      if (setOvf) errOverflow  <= 1'b1;
      if (setUnd) errUnderflow <= 1'b1;
      if (setBad) errBadTarget <= 1'b1;
    end
  end
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import simt_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 8,
  parameter int PCW   = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PCW-1:0]   startPc,
  input  rs_strobe_t       stb,
  input  logic [PCW-1:0]   nextPc,
  input  logic [PCW-1:0]   targetPc,
  input  logic [PCW-1:0]   ipdomPc,
  input  logic [LANES-1:0] condMask,
  output logic [CW-1:0]    depth,
  output logic [PCW-1:0]   topPc,
  output logic [PCW-1:0]   topRpc,
  output logic [LANES-1:0] topMask
);
  logic [PCW-1:0]   pcMem   [DEPTH];
  logic [PCW-1:0]   rpcMem  [DEPTH];
  logic [LANES-1:0] maskMem [DEPTH];
  logic [CW-1:0]    count;
  logic [IW-1:0]    topIdx;
  logic [CW-1:0]    slotRecon, slotNot, slotTaken, newCount;
  logic [LANES-1:0] takenMask, notMask;

  assign depth  = count;
  assign topIdx = IW'(count - CW'(1));

  always_comb begin
    if (count == '0) begin
      topPc   = '0;
      topRpc  = '0;
      topMask = '0;
    end else begin
      topPc   = pcMem[topIdx];
      topRpc  = rpcMem[topIdx];
      topMask = maskMem[topIdx];
    end
  end

  // Slots after removing the old top; each push lands above the previous one
  assign slotRecon = count - CW'(1);
  assign slotNot   = slotRecon + CW'(stb.pushRecon);
  assign slotTaken = slotNot + CW'(stb.pushNot);
  assign newCount  = slotTaken + CW'(stb.pushTaken);

  assign takenMask = condMask & topMask;
  assign notMask   = topMask & ~condMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= CW'(1);
      for (int i = 0; i < DEPTH; i++) begin
        pcMem[i]   <= (i == 0) ? startPc : '0;
        rpcMem[i]  <= (i == 0) ? '1 : '0;
        maskMem[i] <= (i == 0) ? '1 : '0;
      end
    end else begin
      if (stb.setPc) begin
        pcMem[topIdx] <= stb.selTarget ? targetPc : nextPc;
      end
      if (stb.pop) begin
        count <= count - CW'(1);
      end
      if (stb.rebuild) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (stb.pushRecon && CW'(i) == slotRecon) begin
            pcMem[i]   <= ipdomPc;
            rpcMem[i]  <= topRpc;
            maskMem[i] <= topMask;
          end
          if (stb.pushNot && CW'(i) == slotNot) begin
            pcMem[i]   <= nextPc;
            rpcMem[i]  <= ipdomPc;
            maskMem[i] <= notMask;
          end
          if (stb.pushTaken && CW'(i) == slotTaken) begin
            pcMem[i]   <= targetPc;
            rpcMem[i]  <= ipdomPc;
            maskMem[i] <= takenMask;
          end
        end
        count <= newCount;
      end
    end
  end
endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack
  import simt_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 8,
  parameter int PCW   = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PCW-1:0]   startPc,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  output logic             cmdReady,
  input  logic [PCW-1:0]   nextPc,
  input  logic [PCW-1:0]   targetPc,
  input  logic [PCW-1:0]   ipdomPc,
  input  logic [LANES-1:0] condMask,
  output logic [PCW-1:0]   curPc,
  output logic [PCW-1:0]   curRpc,
  output logic [LANES-1:0] curMask,
  output logic             stackEmpty,
  output logic             errOverflow,
  output logic             errUnderflow,
  output logic             errBadTarget
);
  rs_strobe_t    stb;
  logic [CW-1:0] depth;

  rs_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .PCW(PCW)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .nextPc(nextPc), .targetPc(targetPc), .ipdomPc(ipdomPc),
    .condMask(condMask), .depth(depth), .topRpc(curRpc), .topMask(curMask),
    .stb(stb), .cmdReady(cmdReady), .errOverflow(errOverflow),
    .errUnderflow(errUnderflow), .errBadTarget(errBadTarget)
  );

  rs_datapath #(.LANES(LANES), .DEPTH(DEPTH), .PCW(PCW)) uData (
    .clk(clk), .rstN(rstN), .startPc(startPc), .stb(stb),
    .nextPc(nextPc), .targetPc(targetPc), .ipdomPc(ipdomPc),
    .condMask(condMask), .depth(depth), .topPc(curPc), .topRpc(curRpc),
    .topMask(curMask)
  );

  assign stackEmpty = (depth == '0);
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int LANES = 8,
  parameter int PCW   = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [1:0]       cmdOp,
  input logic             cmdReady,
  input logic [PCW-1:0]   nextPc,
  input logic [PCW-1:0]   targetPc,
  input logic [PCW-1:0]   ipdomPc,
  input logic [LANES-1:0] condMask,
  input logic [PCW-1:0]   curPc,
  input logic [PCW-1:0]   curRpc,
  input logic [LANES-1:0] curMask,
  input logic             stackEmpty,
  input logic             errOverflow,
  input logic             errUnderflow,
  input logic             errBadTarget
);
  logic acc;
  assign acc = cmdValid && cmdReady;

  a_r2_step_moves_pc: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdOp == 2'd1 && !stackEmpty && nextPc != curRpc)
    |=> (curPc == $past(nextPc) && curRpc == $past(curRpc) && curMask == $past(curMask)));

  a_r3_empty_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    stackEmpty |-> (curMask == '0 && curPc == '0));

  a_r4_jump_moves_pc: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdOp == 2'd2 && !stackEmpty && targetPc != curRpc)
    |=> (curPc == $past(targetPc) && curMask == $past(curMask)));

  a_r5_taken_on_top: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdOp == 2'd3 && !stackEmpty && targetPc != nextPc
     && targetPc != ipdomPc && (condMask & curMask) != '0)
    |=> ((curPc == $past(targetPc) && curRpc == $past(ipdomPc)) || errOverflow));

  a_r7_busy_after_branch: assert property (@(posedge clk) disable iff (!rstN)
    (acc && cmdOp == 2'd3) |=> !cmdReady);

  a_r7_busy_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReady |=> cmdReady);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errBadTarget |=> errBadTarget);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errOverflow |=> errOverflow);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errUnderflow |=> errUnderflow);
endmodule

bind simt_recon_stack rs_checker #(.LANES(LANES), .PCW(PCW)) uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdReady(cmdReady), .nextPc(nextPc), .targetPc(targetPc),
  .ipdomPc(ipdomPc), .condMask(condMask), .curPc(curPc), .curRpc(curRpc),
  .curMask(curMask), .stackEmpty(stackEmpty), .errOverflow(errOverflow),
  .errUnderflow(errUnderflow), .errBadTarget(errBadTarget)
);

// File: tb/tb_simt_recon_stack.sv
module tb_simt_recon_stack;
  localparam int L = 4;
  localparam int D = 4;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [P-1:0] startPc = 8'h05;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic cmdReady;
  logic [P-1:0] nextPc = '0, targetPc = '0, ipdomPc = '0;
  logic [L-1:0] condMask = '0;
  logic [P-1:0] curPc, curRpc;
  logic [L-1:0] curMask;
  logic stackEmpty, errOverflow, errUnderflow, errBadTarget;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  simt_recon_stack #(.LANES(L), .DEPTH(D), .PCW(P)) dut (
    .clk(clk), .rstN(rstN), .startPc(startPc), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdReady(cmdReady), .nextPc(nextPc), .targetPc(targetPc),
    .ipdomPc(ipdomPc), .condMask(condMask), .curPc(curPc), .curRpc(curRpc),
    .curMask(curMask), .stackEmpty(stackEmpty), .errOverflow(errOverflow),
    .errUnderflow(errUnderflow), .errBadTarget(errBadTarget)
  );

  task automatic chkTop(input logic [P-1:0] ePc, input logic [P-1:0] eRpc,
                        input logic [L-1:0] eMask, input string tag);
    checks++;
    if (curPc !== ePc || curRpc !== eRpc || curMask !== eMask) begin
      failures++;
      $display("FAIL %s: top pc=%h rpc=%h mask=%b expected pc=%h rpc=%h mask=%b",
               tag, curPc, curRpc, curMask, ePc, eRpc, eMask);
    end
  endtask

  task automatic chkBit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cmdValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Drive one command for one accepted cycle; returns at the negedge after it took effect
  task automatic issue(input logic [1:0] op, input logic [P-1:0] np,
                       input logic [P-1:0] tp, input logic [P-1:0] ip,
                       input logic [L-1:0] cm);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdOp = op; nextPc = np; targetPc = tp; ipdomPc = ip; condMask = cm;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdOp = 2'd0;
  endtask

  initial begin
    logic [P-1:0] ePc [3];
    logic [P-1:0] eRpc [3];
    logic [L-1:0] eMask [3];
    int n;

    // R1 reset state
    doReset();
    chkTop(8'h05, 8'hFF, 4'hF, "R1 reset entry");
    chkBit(stackEmpty, 1'b0, "R1 not empty");
    chkBit(errOverflow | errUnderflow | errBadTarget, 1'b0, "R1 errors clear");
    chkBit(cmdReady, 1'b1, "R1 ready");

    // R2 step, R3 step to reconvergence pops, R10 underflow
    issue(2'd1, 8'h06, 8'h00, 8'h00, 4'h0);
    chkTop(8'h06, 8'hFF, 4'hF, "R2 step");
    issue(2'd1, 8'h07, 8'h00, 8'h00, 4'h0);
    chkTop(8'h07, 8'hFF, 4'hF, "R2 second step");
    issue(2'd1, 8'hFF, 8'h00, 8'h00, 4'h0);
    chkBit(stackEmpty, 1'b1, "R3 last pop empties");
    chkTop(8'h00, 8'h00, 4'h0, "R3 empty outputs zero");
    chkBit(errUnderflow, 1'b0, "R3 no underflow on legal pop");
    issue(2'd1, 8'h10, 8'h00, 8'h00, 4'h0);
    chkBit(errUnderflow, 1'b1, "R10 step on empty");
    chkBit(stackEmpty, 1'b1, "R10 stays empty");
    issue(2'd3, 8'h11, 8'h20, 8'h30, 4'h3);
    chkBit(stackEmpty, 1'b1, "R10 branch on empty ignored");

    // R4 jump
    doReset();
    issue(2'd2, 8'h00, 8'h44, 8'h00, 4'h0);
    chkTop(8'h44, 8'hFF, 4'hF, "R4 jump moves pc");
    issue(2'd2, 8'h00, 8'hFF, 8'h00, 4'h0);
    chkBit(stackEmpty, 1'b1, "R4 jump to rpc pops");

    // R5/R6 sweep A: all addresses distinct, then drain
    for (int m = 0; m < 16; m++) begin
      doReset();
      issue(2'd3, 8'h11, 8'h20, 8'h30, L'(m));
      n = 0;
      ePc[n] = 8'h30; eRpc[n] = 8'hFF; eMask[n] = 4'hF; n++;
      if ((~m & 15) != 0) begin
        ePc[n] = 8'h11; eRpc[n] = 8'h30; eMask[n] = L'(~m & 15); n++;
      end
      if (m != 0) begin
        ePc[n] = 8'h20; eRpc[n] = 8'h30; eMask[n] = L'(m); n++;
      end
      for (int k = n - 1; k >= 0; k--) begin
        chkTop(ePc[k], eRpc[k], eMask[k], $sformatf("R5 sweepA m=%0d level=%0d", m, k));
        issue(2'd2, 8'h00, eRpc[k], 8'h00, 4'h0);
      end
      chkBit(stackEmpty, 1'b1, $sformatf("R5 sweepA m=%0d drained", m));
    end

    // R6 sweep B: fall-through is the post-dominator
    for (int m = 0; m < 16; m++) begin
      doReset();
      issue(2'd3, 8'h11, 8'h20, 8'h11, L'(m));
      if (m != 0) chkTop(8'h20, 8'h11, L'(m), $sformatf("R6 sweepB m=%0d", m));
      else        chkTop(8'h11, 8'hFF, 4'hF, "R6 sweepB none taken");
    end

    // R5 sweep C: saved rpc is the post-dominator, no continuation entry
    for (int m = 0; m < 16; m++) begin
      doReset();
      issue(2'd3, 8'h11, 8'h20, 8'hFF, L'(m));
      if (m != 0) chkTop(8'h20, 8'hFF, L'(m), $sformatf("R5 sweepC m=%0d", m));
      else        chkTop(8'h11, 8'hFF, 4'hF, "R5 sweepC none taken");
      if (m == 15) begin
        issue(2'd2, 8'h00, 8'hFF, 8'h00, 4'h0);
        chkBit(stackEmpty, 1'b1, "R6 uniform taken leaves single entry");
      end
    end

    // R7 busy cycle and ignored command
    doReset();
    issue(2'd3, 8'h11, 8'h20, 8'h30, 4'h5);
    chkBit(cmdReady, 1'b0, "R7 busy after branch");
    cmdOp = 2'd2; targetPc = 8'h77; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd0;
    chkTop(8'h20, 8'h30, 4'h5, "R7 command during busy ignored");
    chkBit(cmdReady, 1'b1, "R7 ready again");

    // R8 target equals fall-through
    doReset();
    issue(2'd3, 8'h11, 8'h11, 8'h30, 4'h3);
    chkBit(errBadTarget, 1'b1, "R8 flag set");
    chkTop(8'h05, 8'hFF, 4'hF, "R8 stack unchanged");

    // R9 depth limit: exactly full fits, one more overflows
    doReset();
    issue(2'd3, 8'h11, 8'h20, 8'h30, 4'h5);
    issue(2'd3, 8'h21, 8'h28, 8'h40, 4'h5);
    chkTop(8'h28, 8'h40, 4'h5, "R9 full stack fits");
    chkBit(errOverflow, 1'b0, "R9 no overflow at capacity");
    doReset();
    issue(2'd3, 8'h11, 8'h20, 8'h30, 4'h5);
    issue(2'd3, 8'h21, 8'h28, 8'h40, 4'h1);
    chkBit(errOverflow, 1'b1, "R9 overflow flagged");
    chkTop(8'h20, 8'h30, 4'h5, "R9 stack unchanged on overflow");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule